// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block decides which clock domains of a small system keep running. Software programs a sleep control register with an enable bit and a three-bit mode code. It also programs a power reduction register that holds one stop bit per peripheral. A one-cycle sleep request strobe moves the controller into the selected sleep mode. From then on it drives separate enables for the CPU clock, the shared peripheral clock, the real-time-counter clock and the system oscillators. A one-cycle wake pulse brings every domain back on.

The sleep modes differ in which clocks they stop:

| Mode | Code | CPU | Peripheral | RTC | Oscillators |
|---|---|---|---|---|---|
| Idle | 000 | off | on | on | on |
| Power-down | 010 | off | off | off | off |
| Power-save | 011 | off | off | on | off |
| Standby | 110 | off | off | off | on |
| Extended standby | 111 | off | off | on | on |

On top of the mode gating, each peripheral has its own clock enable. That enable is off whenever the peripheral's stop bit is set or the shared peripheral clock is off. A stopped peripheral keeps its state, and the block flags register accesses to it as blocked. Peripherals that a build does not contain are described by a presence mask parameter. Their stop bits do not exist.

Top module: `slpgate_ctrl`

## Requirements
- R1: Register address 0 is the sleep control register. Bit 0 is the sleep enable and bits 3:1 are the mode code. Bits 7:4 read as zero and ignore writes. The register resets to zero.
- R2: A sleep request while the sleep enable is 0 is ignored, and all clock enables stay high.
- R3: A sleep request with code 001, 100 or 101 is ignored, and the block stays active.
- R4: A sleep request with enable set and code 000 (Idle) drops only the CPU clock enable, starting one cycle after the request edge.
- R5: Code 010 (Power-down) drops the CPU, peripheral, RTC and oscillator enables.
- R6: Code 011 (Power-save) drops the CPU, peripheral and oscillator enables and keeps the RTC enable high.
- R7: Code 110 (Standby) drops the CPU, peripheral and RTC enables and keeps the oscillator enable high.
- R8: Code 111 (Extended standby) drops the CPU and peripheral enables and keeps the RTC and oscillator enables high.
- R9: A wake pulse returns all enables high at the next clock edge. Wake takes priority over a sleep request in the same cycle, and both register contents are unchanged by a wake.
- R10: In the power reduction register, bit i set clears peripheral clock enable i and sets access-blocked output i. Each peripheral clock enable is the shared peripheral enable ANDed with the inverse of its bit, so in every mode except Active and Idle all peripheral clock enables are low.
- R11: Bits of absent peripherals (presence mask bit 0) ignore writes, read as 0, never block access and never stop that peripheral's clock beyond the mode gating.
- R12: Register address 1 is the power reduction register, with bit i for peripheral i. It resets to zero.
- R13: A sleep request while already in a sleep mode is ignored. The mode holds until a wake pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 sleep control, 1 power reduction |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data for the selected register |
| sleep_req | input | 1 | One-cycle sleep request strobe |
| wake | input | 1 | One-cycle wake event |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Shared peripheral clock enable |
| rtc_clk_en | output | 1 | Real-time-counter clock enable |
| osc_en | output | 1 | System oscillator enable |
| dev_clk_en | output | NPER | Per-peripheral clock enables |
| dev_access_blk | output | NPER | Per-peripheral register access blocked |

## Verification
The assertions assume that the sleep request and the wake event are single-cycle strobes with no fixed relation to each other. They also assume that register writes can happen in any mode, including the same cycle as a request. The stimulus drives every input at the falling edge and keeps each strobe high for exactly one cycle. It deliberately overlaps a wake with a request, sends requests while already asleep, and uses a write that sets the reserved and absent bits. A behavioural reference model in the bench tracks mode, enable, code and stop bits from the same inputs, and its predictions are compared with every output after each rising edge.

// File: rtl/slpgate_pkg.sv
package slpgate_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE = 3'd0,
        ST_IDLE   = 3'd1,
        ST_PDOWN  = 3'd2,
        ST_PSAVE  = 3'd3,
        ST_STDBY  = 3'd4,
        ST_XSTDBY = 3'd5
    } pwr_state_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic rtc;
        logic osc;
    } clk_gate_t;

    localparam logic [2:0] CODE_IDLE   = 3'b000;
    localparam logic [2:0] CODE_PDOWN  = 3'b010;
    localparam logic [2:0] CODE_PSAVE  = 3'b011;
    localparam logic [2:0] CODE_STDBY  = 3'b110;
    localparam logic [2:0] CODE_XSTDBY = 3'b111;

    function automatic logic code_valid(logic [2:0] c);
        return (c == CODE_IDLE) || (c == CODE_PDOWN) || (c == CODE_PSAVE) ||
               (c == CODE_STDBY) || (c == CODE_XSTDBY);
    endfunction

    function automatic pwr_state_e code_to_state(logic [2:0] c);
        pwr_state_e s;
        case (c)
            CODE_IDLE:   s = ST_IDLE;
            CODE_PDOWN:  s = ST_PDOWN;
            CODE_PSAVE:  s = ST_PSAVE;
            CODE_STDBY:  s = ST_STDBY;
            CODE_XSTDBY: s = ST_XSTDBY;
            default:     s = ST_ACTIVE;
        endcase
        return s;
    endfunction

    function automatic clk_gate_t state_gates(pwr_state_e s);
        clk_gate_t g;
        case (s)
            ST_IDLE:   g = '{cpu: 1'b0, per: 1'b1, rtc: 1'b1, osc: 1'b1};
            ST_PDOWN:  g = '{cpu: 1'b0, per: 1'b0, rtc: 1'b0, osc: 1'b0};
            ST_PSAVE:  g = '{cpu: 1'b0, per: 1'b0, rtc: 1'b1, osc: 1'b0};
            ST_STDBY:  g = '{cpu: 1'b0, per: 1'b0, rtc: 1'b0, osc: 1'b1};
            ST_XSTDBY: g = '{cpu: 1'b0, per: 1'b0, rtc: 1'b1, osc: 1'b1};
            default:   g = '{cpu: 1'b1, per: 1'b1, rtc: 1'b1, osc: 1'b1};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/slpgate_regs.sv
module slpgate_regs #(
    parameter int              DW      = 8,
    parameter int              NPER    = 8,
    parameter logic [NPER-1:0] PRESENT = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic            addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            sen,
    output logic [2:0]      code,
    output logic [NPER-1:0] pr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sen  <= 1'b0;
            code <= 3'b000;
            pr   <= '0;
        end else if (we) begin
            if (!addr) begin
                sen  <= wdata[0];
                code <= wdata[3:1];
            end else begin
                pr <= wdata[NPER-1:0] & PRESENT;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (!addr) rdata[3:0]      = {code, sen};
        else       rdata[NPER-1:0] = pr;
    end

    p_ctrl_write_r1: assert property (@(posedge clk) disable iff (rst)
        (we && !addr) |=> ({code, sen} == $past(wdata[3:0])));
    p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(code) && $stable(sen) && $stable(pr)));
    p_absent_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (we && addr) |=> ((pr & ~PRESENT) == '0));
endmodule

// File: rtl/slpgate_fsm.sv
module slpgate_fsm
    import slpgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic       wake,
    input  logic       sen,
    input  logic [2:0] code,
    output pwr_state_e state
);
    pwr_state_e state_nx;

    always_comb begin
        state_nx = state;
        if (wake)
            state_nx = ST_ACTIVE;
        else if (state == ST_ACTIVE && sleep_req && sen && code_valid(code))
            state_nx = code_to_state(code);
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_ACTIVE;
        else     state <= state_nx;
    end

    p_sen_low_stays_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE && !sen) |=> (state == ST_ACTIVE));
    p_reserved_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE && !code_valid(code)) |=> (state == ST_ACTIVE));
    p_wake_active_r9: assert property (@(posedge clk) disable iff (rst)
        wake |=> (state == ST_ACTIVE));
    p_sleep_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (state != ST_ACTIVE && !wake) |=> $stable(state));
endmodule

// File: rtl/slpgate_perclk.sv
module slpgate_perclk #(
    parameter int              NPER    = 8,
    parameter logic [NPER-1:0] PRESENT = '1
) (
    input  logic            per_en,
    input  logic [NPER-1:0] pr,
    output logic [NPER-1:0] dev_clk_en,
    output logic [NPER-1:0] access_blk
);
    for (genvar i = 0; i < NPER; i++) begin : g_dev
        if (PRESENT[i]) begin : g_present
            assign dev_clk_en[i] = per_en & ~pr[i];
            assign access_blk[i] = pr[i];
        end else begin : g_absent
            logic unused_pr;
            assign unused_pr     = pr[i];
            assign dev_clk_en[i] = per_en;
            assign access_blk[i] = 1'b0;
        end
    end
endmodule

// File: rtl/slpgate_ctrl.sv
module slpgate_ctrl
    import slpgate_pkg::*;
#(
    parameter int              DW      = 8,
    parameter int              NPER    = 8,
    parameter logic [NPER-1:0] PRESENT = 8'h7F
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic            reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            sleep_req,
    input  logic            wake,
    output logic            cpu_clk_en,
    output logic            per_clk_en,
    output logic            rtc_clk_en,
    output logic            osc_en,
    output logic [NPER-1:0] dev_clk_en,
    output logic [NPER-1:0] dev_access_blk
);
    logic            sen;
    logic [2:0]      code;
    logic [NPER-1:0] pr;
    pwr_state_e      state;
    clk_gate_t       gates;

    slpgate_regs #(.DW(DW), .NPER(NPER), .PRESENT(PRESENT)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .sen(sen), .code(code), .pr(pr)
    );

    slpgate_fsm u_fsm (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake(wake),
        .sen(sen), .code(code), .state(state)
    );

    assign gates      = state_gates(state);
    assign cpu_clk_en = gates.cpu;
    assign per_clk_en = gates.per;
    assign rtc_clk_en = gates.rtc;
    assign osc_en     = gates.osc;

    slpgate_perclk #(.NPER(NPER), .PRESENT(PRESENT)) u_perclk (
        .per_en(per_clk_en), .pr(pr), .dev_clk_en(dev_clk_en), .access_blk(dev_access_blk)
    );

    p_cpu_gated_first_r4: assert property (@(posedge clk) disable iff (rst)
        (!per_clk_en || !rtc_clk_en || !osc_en) |-> !cpu_clk_en);
    p_deep_devclk_off_r10: assert property (@(posedge clk) disable iff (rst)
        !per_clk_en |-> (dev_clk_en == '0));
    p_absent_unblocked_r11: assert property (@(posedge clk) disable iff (rst)
        ((dev_access_blk & ~PRESENT) == '0));
    p_enter_only_on_req_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && !sleep_req) |=> cpu_clk_en);
endmodule

// File: tb/slpgate_ctrl_test.sv
module slpgate_ctrl_test;
    localparam int DW = 8;
    localparam int NPER = 8;
    localparam logic [7:0] PRES = 8'h7F;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0, reg_addr = 1'b0, sleep_req = 1'b0, wake = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic cpu_clk_en, per_clk_en, rtc_clk_en, osc_en;
    logic [NPER-1:0] dev_clk_en, dev_access_blk;

    always #2.5 clk = ~clk;

    slpgate_ctrl #(.DW(DW), .NPER(NPER), .PRESENT(PRES)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_req(sleep_req),
        .wake(wake), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .rtc_clk_en(rtc_clk_en), .osc_en(osc_en), .dev_clk_en(dev_clk_en),
        .dev_access_blk(dev_access_blk)
    );

    int checks = 0, fails = 0, cycles = 0;
    string cur_req = "R1";

    // reference model: mode 0 active,1 idle,2 pdown,3 psave,4 standby,5 ext standby
    int m_mode = 0;
    logic m_sen = 0;
    logic [2:0] m_code = 0;
    logic [7:0] m_pr = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m_mode <= 0; m_sen <= 0; m_code <= 0; m_pr <= 0;
        end else begin
            if (reg_we && !reg_addr) begin m_sen <= reg_wdata[0]; m_code <= reg_wdata[3:1]; end
            if (reg_we && reg_addr) m_pr <= reg_wdata & PRES;
            if (wake) m_mode <= 0;
            else if (m_mode == 0 && sleep_req && m_sen) begin
                case (m_code)
                    3'd0: m_mode <= 1;
                    3'd2: m_mode <= 2;
                    3'd3: m_mode <= 3;
                    3'd6: m_mode <= 4;
                    3'd7: m_mode <= 5;
                    default: m_mode <= 0;
                endcase
            end
        end
    end

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        begin
            logic e_per, e_rtc, e_osc;
            logic [7:0] e_rd;
            e_per = (m_mode <= 1);
            e_rtc = (m_mode == 0 || m_mode == 1 || m_mode == 3 || m_mode == 5);
            e_osc = (m_mode == 0 || m_mode == 1 || m_mode == 4 || m_mode == 5);
            e_rd  = reg_addr ? m_pr : {4'b0, m_code, m_sen};
            cmp("cpu_clk_en", 32'(cpu_clk_en), 32'(m_mode == 0));
            cmp("per_clk_en", 32'(per_clk_en), 32'(e_per));
            cmp("rtc_clk_en", 32'(rtc_clk_en), 32'(e_rtc));
            cmp("osc_en", 32'(osc_en), 32'(e_osc));
            cmp("dev_clk_en", 32'(dev_clk_en), 32'({8{e_per}} & ~m_pr));
            cmp("dev_access_blk", 32'(dev_access_blk), 32'(m_pr));
            cmp("reg_rdata", 32'(reg_rdata), 32'(e_rd));
        end
    end

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask
    task automatic rq();
        @(negedge clk); sleep_req = 1; @(negedge clk); sleep_req = 0;
    endtask
    task automatic wk();
        @(negedge clk); wake = 1; @(negedge clk); wake = 0;
    endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask
    task automatic try_mode(string tag, logic [2:0] c);
        cur_req = tag;
        wr(0, {4'b0, c, 1'b1});
        rq(); idle(3);
        reg_addr = 1; idle(1); reg_addr = 0;
        wk(); idle(2);
    endtask

    initial begin
        idle(3); rst = 0;
        cur_req = "R12"; reg_addr = 1; idle(2);
        cur_req = "R1";  reg_addr = 0; idle(1);
        wr(0, 8'hF5); idle(2);
        cur_req = "R2"; wr(0, 8'h04); rq(); idle(3);
        cur_req = "R3"; wr(0, 8'h03); rq(); idle(2);
        wr(0, 8'h09); rq(); idle(2);
        wr(0, 8'h0B); rq(); idle(2);
        try_mode("R4", 3'b000);
        try_mode("R5", 3'b010);
        try_mode("R6", 3'b011);
        try_mode("R7", 3'b110);
        try_mode("R8", 3'b111);
        cur_req = "R13"; wr(0, 8'h01); rq(); wr(0, 8'h05); rq(); idle(2);
        cur_req = "R9"; wk(); idle(1);
        @(negedge clk); wake = 1; sleep_req = 1; @(negedge clk); wake = 0; sleep_req = 0;
        idle(2);
        cur_req = "R11"; wr(1, 8'hFF); reg_addr = 1; idle(2);
        cur_req = "R10"; wr(1, 8'h25); reg_addr = 1; idle(1);
        wr(0, 8'h01); rq(); reg_addr = 1; idle(2);
        wk(); wr(0, 8'h05); rq(); reg_addr = 1; idle(2);
        cur_req = "R9"; wk(); idle(2);
        cur_req = "R10"; wr(1, 8'h00); reg_addr = 1; idle(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        fails++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule